// File: doc/BRIEF.md
# Multiplier and Switch Readback Port

This block is a small memory-mapped peripheral that occupies a 4 KiB window of a processor's address space, from 0x5000 to 0x5FFF. The host writes two 8-bit unsigned operands and reads their 16-bit product back as two separate bytes. A third 8-bit register is scratch storage that the host can write and read back.

Only a few address bits take part in decoding. Because of that, every register appears at many addresses across the window. A read that matches no register returns a two-bit switch value in the top two bits of the byte. This value moves one step forward every time the console reset button is pressed.

All state uses a synchronous, active-high power-on reset. Read data comes from a register: a read issued on one clock edge can be sampled after that edge, and it then stays stable until the next in-window read.

Top module: `mdp_port`

## Requirements
- R1: An access is in the window when addr[15:12] equals 0x5. Inside the window, the register is chosen from (addr AND 0x5C03). As a result, for example, 0x5BFC reaches the same register as 0x5800, and 0x5AFD reaches the same register as 0x5801.
- R2: A write whose masked address is 0x5800 loads operand A. A write whose masked address is 0x5801 loads operand B.
- R3: A read whose masked address is 0x5800 returns bits [7:0] of the unsigned product A×B.
- R4: A read whose masked address is 0x5801 returns bits [15:8] of the unsigned product A×B.
- R5: A write whose masked address is 0x5803 stores the scratch byte. A read at that masked address returns it.
- R6: A read of any other in-window masked address returns the switch value. Bits [7:6] hold the switch count and bits [5:0] are 0.
- R7: Each cycle with dip_step high advances the switch count by one. Bits [7:6] therefore go 0x00 → 0x40 → 0x80 → 0xC0 → 0x00.
- R8: Writes to a masked address that names no writable register have no effect on any register. Neither do writes outside the window.
- R9: rd_data changes only on a clock edge where rd_en is high and the address is in the window. A read outside the window leaves rd_data unchanged.
- R10: rst high at a clock edge clears both operands, the scratch byte, the switch count and rd_data to zero.
- R11: A product read issued in the cycle right after an operand write already reflects the new operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| addr | input | 16 | Access address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data |
| dip_step | input | 1 | One-cycle pulse per press of the reset button |

## Verification
On every cycle, the assertions check the following:
- that each write strobe selects at most one register;
- that a register loads the written byte exactly when it is selected and holds its value otherwise;
- that the switch count moves by one only on a pulse;
- that rd_data holds between in-window reads;
- that a product-low read returns the low byte of the product that was present at the read;
- that a switch read has zero low bits.

Some behaviour can only be shown by the bench's scenarios, which drive the ports and compare against expected values:
- the arithmetic values;
- the mirror addresses;
- the wrap of the switch count;
- operands that are ready in the next cycle;
- clearing by reset in the middle of a run.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int unsigned NREG    = 3;
  localparam int unsigned REG_OPA = 0;
  localparam int unsigned REG_OPB = 1;
  localparam int unsigned REG_SCR = 2;

  typedef enum logic [1:0] {
    SEL_PROD_LO = 2'd0,
    SEL_PROD_HI = 2'd1,
    SEL_SCRATCH = 2'd2,
    SEL_SWITCH  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/mdp_decode.sv
module mdp_decode
  import mdp_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 16,
  parameter int unsigned         WIN_LOG2 = 12,
  parameter logic [ADDR_W-1:0]   WIN_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0]   DEC_MASK = 16'h5C03,
  parameter logic [ADDR_W-1:0]   ADR_OPA  = 16'h5800,
  parameter logic [ADDR_W-1:0]   ADR_OPB  = 16'h5801,
  parameter logic [ADDR_W-1:0]   ADR_SCR  = 16'h5803
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output rd_sel_e           rd_sel,
  output logic [NREG-1:0]   reg_hit
);
  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked  = addr & DEC_MASK;
    in_win  = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
    reg_hit = '0;
    rd_sel  = SEL_SWITCH;
    if (masked == ADR_OPA) begin
      reg_hit[REG_OPA] = 1'b1;
      rd_sel           = SEL_PROD_LO;
    end else if (masked == ADR_OPB) begin
      reg_hit[REG_OPB] = 1'b1;
      rd_sel           = SEL_PROD_HI;
    end else if (masked == ADR_SCR) begin
      reg_hit[REG_SCR] = 1'b1;
      rd_sel           = SEL_SCRATCH;
    end
  end
endmodule

// File: rtl/mdp_regfile.sv
module mdp_regfile
  import mdp_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0]             wr_sel,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [NREG-1:0][DATA_W-1:0] q
);
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel)); // R1

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            q[i] <= '0;
      else if (wr_sel[i]) q[i] <= wr_data;
    end

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
      wr_sel[i] |=> q[i] == $past(wr_data)); // R2
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[i] |=> $stable(q[i])); // R8
  end
endmodule

// File: rtl/mdp_mul.sv
module mdp_mul #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  output logic [2*DATA_W-1:0] prod
);
  localparam int unsigned PW = 2 * DATA_W;

  always_comb begin
    prod = PW'(op_a) * PW'(op_b);
  end
endmodule

// File: rtl/mdp_switch.sv
module mdp_switch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SW_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [DATA_W-1:0] value
);
  localparam int unsigned LOW_W = DATA_W - SW_W;

  logic [SW_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign value = {cnt, {LOW_W{1'b0}}};

  AST_SW_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt == $past(cnt) + 1'b1); // R7
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R7
endmodule

// File: rtl/mdp_port.sv
module mdp_port
  import mdp_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       SW_W     = 2,
  parameter int unsigned       WIN_LOG2 = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] DEC_MASK = 16'h5C03,
  parameter logic [ADDR_W-1:0] ADR_OPA  = 16'h5800,
  parameter logic [ADDR_W-1:0] ADR_OPB  = 16'h5801,
  parameter logic [ADDR_W-1:0] ADR_SCR  = 16'h5803
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dip_step
);
  localparam int unsigned PW    = 2 * DATA_W;
  localparam int unsigned LOW_W = DATA_W - SW_W;

  logic                        in_win;
  rd_sel_e                     rd_sel;
  logic [NREG-1:0]             reg_hit;
  logic [NREG-1:0]             wr_sel;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [PW-1:0]               prod;
  logic [DATA_W-1:0]           sw_val;
  logic [DATA_W-1:0]           rd_next;
  logic                        rd_fire;

  mdp_decode #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE),
    .DEC_MASK(DEC_MASK), .ADR_OPA(ADR_OPA), .ADR_OPB(ADR_OPB), .ADR_SCR(ADR_SCR)
  ) u_decode (
    .addr(addr), .in_win(in_win), .rd_sel(rd_sel), .reg_hit(reg_hit)
  );

  assign wr_sel  = (wr_en && in_win) ? reg_hit : '0;
  assign rd_fire = rd_en && in_win;

  mdp_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data), .q(regs)
  );

  mdp_mul #(.DATA_W(DATA_W)) u_mul (
    .op_a(regs[REG_OPA]), .op_b(regs[REG_OPB]), .prod(prod)
  );

  mdp_switch #(.DATA_W(DATA_W), .SW_W(SW_W)) u_switch (
    .clk(clk), .rst(rst), .step(dip_step), .value(sw_val)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_PROD_LO: rd_next = prod[DATA_W-1:0];
      SEL_PROD_HI: rd_next = prod[PW-1:DATA_W];
      SEL_SCRATCH: rd_next = regs[REG_SCR];
      default:     rd_next = sw_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_fire) rd_data <= rd_next;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rd_data)); // R9
  AST_SW_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rd_sel == SEL_SWITCH) |=> rd_data[LOW_W-1:0] == '0); // R6
  AST_PROD_LO: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && rd_sel == SEL_PROD_LO) |=> rd_data == $past(prod[DATA_W-1:0])); // R3
endmodule

// File: tb/mdp_port_tb.sv
`timescale 1ns/1ps
module mdp_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        dip_step = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mdp_port u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dip_step(dip_step)
  );

  // {is_write, addr, wdata, expected_read}
  localparam int NV = 22;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h5800, 8'h00, 8'h00},  // R10 reset product lo
    {1'b0, 16'h5801, 8'h00, 8'h00},  // R10 reset product hi
    {1'b0, 16'h5803, 8'h00, 8'h00},  // R10 reset scratch
    {1'b0, 16'h5802, 8'h00, 8'h00},  // R6 switch at reset
    {1'b1, 16'h5800, 8'h12, 8'h00},  // R2 A
    {1'b1, 16'h5801, 8'h34, 8'h00},  // R2 B
    {1'b0, 16'h5800, 8'h00, 8'hA8},  // R3 R11 next-cycle read
    {1'b0, 16'h5801, 8'h00, 8'h03},  // R4
    {1'b1, 16'h5BFC, 8'hFF, 8'h00},  // R1 mirror of A
    {1'b1, 16'h5A01, 8'hFF, 8'h00},  // R1 mirror of B
    {1'b0, 16'h5800, 8'h00, 8'h01},  // R3
    {1'b0, 16'h5AFD, 8'h00, 8'hFE},  // R1 R4 mirror read
    {1'b1, 16'h5907, 8'h5A, 8'h00},  // R5 mirror of scratch
    {1'b0, 16'h5803, 8'h00, 8'h5A},  // R5
    {1'b1, 16'h5802, 8'h77, 8'h00},  // R8 no register
    {1'b1, 16'h6800, 8'h99, 8'h00},  // R8 outside window
    {1'b1, 16'h4801, 8'h99, 8'h00},  // R8 outside window
    {1'b0, 16'h5800, 8'h00, 8'h01},  // R8 A unchanged
    {1'b0, 16'h5801, 8'h00, 8'hFE},  // R8 B unchanged
    {1'b0, 16'h5F03, 8'h00, 8'h00},  // R6 unused masked addr
    {1'b1, 16'h5800, 8'h00, 8'h00},  // R2 A = 0
    {1'b0, 16'h5801, 8'h00, 8'h00}   // R11 zero product hi
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_step();
    dip_step = 1'b1;
    @(negedge clk);
    dip_step = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 rd_data after reset", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) do_write(VEC[i][31:16], VEC[i][15:8]);
      else begin
        do_read(VEC[i][31:16]);
        check($sformatf("vector %0d addr %04h", i, VEC[i][31:16]), rd_data, VEC[i][7:0]);
      end
    end

    // R7: switch count steps and wraps
    pulse_step();
    do_read(16'h5C00); check("R7 step 1", rd_data, 8'h40);
    pulse_step();
    do_read(16'h5000); check("R7 step 2", rd_data, 8'h80);
    pulse_step();
    do_read(16'h5802); check("R7 step 3", rd_data, 8'hC0);
    pulse_step();
    do_read(16'h5FFE); check("R7 wrap", rd_data, 8'h00);
    pulse_step();

    // R9: out-of-window read holds rd_data
    do_read(16'h5803); check("R9 scratch read", rd_data, 8'h5A);
    do_read(16'h6800); check("R9 hold after outside read", rd_data, 8'h5A);
    @(negedge clk);    check("R9 hold while idle", rd_data, 8'h5A);

    // R11: write B then read low product next cycle
    do_write(16'h5800, 8'h0F);
    do_write(16'h5801, 8'h10);
    do_read(16'h5800); check("R11 product lo", rd_data, 8'hF0);

    // R10: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 rd_data cleared", rd_data, 8'h00);
    do_read(16'h5801); check("R10 product cleared", rd_data, 8'h00);
    do_read(16'h5803); check("R10 scratch cleared", rd_data, 8'h00);
    do_read(16'h5C01); check("R10 switch cleared", rd_data, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule